// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block is the address-keeping part of one channel in a DMA engine that moves data between two devices, called A and B. Each device has two registers: a live address counter and a start register for the next block. The block length has the same pair: a live count of the transfers still to do, and a reload value. A control register holds four settings. The first is a direction bit that picks which device is the source. The second is a per-device adjust enable. The third is a per-device step code. The last is a channel enable.

Each time the data path reports a completed transfer, the sequencer acts on its counters. It steps the address counters whose adjust is enabled and lowers the length count by one. When that transfer ends the block, it reloads all three counters from their start registers instead, and it raises a sticky block-complete flag. Software reads and writes the block through a small word-addressed register port. The current source and destination addresses are driven out for the bus master.

Register indices on `reg_addr`: 0 = A counter, 1 = A start, 2 = B counter, 3 = B start, 4 = length counter, 5 = length reload, 6 = control, 7 = status. The control fields are:
- bit 0: enable
- bit 1: direction
- bit 2: adjust A
- bit 3: adjust B
- bits 5:4: step code for A
- bits 7:6: step code for B

Status bit 0 is the block-complete flag.

Top module: `dseq_channel`

## Requirements
- R1: The four address registers (indices 0 to 3) keep only 24 bits. Bits 31:24 read as zero whatever was written to them.
- R2: A write to a start register (index 1, 3 or 5) leaves the running counter unchanged until the next reload.
- R3: With the direction bit (control bit 1) at 0, `src_addr` shows the A counter and `dst_addr` shows the B counter. With the bit at 1, the two roles are swapped.
- R4: When a device's adjust bit (control bit 2 for A, bit 3 for B) is 0, that device's counter holds its value across transfers.
- R5: Step codes 00, 01 and 10 add 1, 2 and 4 to an adjusted counter on each transfer. Code 11 adds 0.
- R6: Each `xfer_done` pulse while enabled lowers the length counter by one, provided the count is above 1.
- R7: A pulse while the length counter is 1 (or 0) ends the block. Both address counters load their start values, the length counter loads its reload value, no step is applied, and status bit 0 is set.
- R8: Status bit 0 is sticky. Writing 1 to it clears it and writing 0 has no effect. A block end in the same cycle as a clear write leaves the bit set.
- R9: While the enable bit (control bit 0) is 0, `xfer_done` pulses change no counter.
- R10: A control write that takes the enable bit from 0 to 1 copies all three start registers into their counters.
- R11: Address counters wrap modulo 2^24, so 0xFFFFFF plus 2 gives 0x000001.
- R12: `rd_data` shows the addressed register on the clock edge after the one that samples `rd_en`, and holds between reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register index |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| xfer_done | input | 1 | One-cycle pulse per completed transfer |
| src_addr | output | 24 | Current source address |
| dst_addr | output | 24 | Current destination address |
| blk_done | output | 1 | Sticky block-complete flag |

## Verification
Two functions can fall in the same cycle: a block end, which sets the flag, and a software write of 1 to the status bit, which clears it. The bench provokes this by bringing the length counter to 1. It then asserts `xfer_done` and the status clear write on the same clock edge. The flag must read back as 1 afterwards, and the counters must show the reload values. A second collision is also tested: a start register is written while transfers continue. The running counter must keep stepping from its old value until the block ends.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

  typedef enum logic [2:0] {
    IDX_A_CNT   = 3'd0,
    IDX_A_START = 3'd1,
    IDX_B_CNT   = 3'd2,
    IDX_B_START = 3'd3,
    IDX_L_CNT   = 3'd4,
    IDX_L_RLD   = 3'd5,
    IDX_CTRL    = 3'd6,
    IDX_STAT    = 3'd7
  } reg_idx_e;

  typedef struct packed {
    logic [1:0] step_b;
    logic [1:0] step_a;
    logic       adj_b;
    logic       adj_a;
    logic       dir;
    logic       en;
  } ctrl_t;

  function automatic logic [2:0] step_of(input logic [1:0] code);
    case (code)
      2'b00:   step_of = 3'd1;
      2'b01:   step_of = 3'd2;
      2'b10:   step_of = 3'd4;
      default: step_of = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/dseq_ptr.sv
module dseq_ptr #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cnt_wr,
  input  logic          start_wr,
  input  logic [AW-1:0] wdata,
  input  logic          load,
  input  logic          step_en,
  input  logic [2:0]    step,
  output logic [AW-1:0] cnt,
  output logic [AW-1:0] start
);

  always_ff @(posedge clk) begin
    if (rst) begin
      start <= '0;
    end else if (start_wr) begin
      start <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cnt_wr) begin
      cnt <= wdata;
    end else if (load) begin
      cnt <= start;
    end else if (step_en) begin
      cnt <= cnt + AW'(step);
    end
  end

endmodule

// File: rtl/dseq_len.sv
module dseq_len #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cnt_wr,
  input  logic          rld_wr,
  input  logic [LW-1:0] wdata,
  input  logic          go_load,
  input  logic          tick,
  output logic          wrap,
  output logic [LW-1:0] cnt,
  output logic [LW-1:0] rld
);

  localparam logic [LW-1:0] ONE = LW'(1);

  assign wrap = tick && (cnt <= ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      rld <= '0;
    end else if (rld_wr) begin
      rld <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cnt_wr) begin
      cnt <= wdata;
    end else if (go_load || wrap) begin
      cnt <= rld;
    end else if (tick) begin
      cnt <= cnt - ONE;
    end
  end

endmodule

// File: rtl/dseq_channel.sv
module dseq_channel #(
  parameter int AW = 24,
  parameter int LW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          xfer_done,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic          blk_done
);
  import dseq_pkg::*;

  localparam int NDEV = 2;
  localparam int CW   = $bits(ctrl_t);

  ctrl_t   ctrl_q;
  logic    stat_q;
  logic    en_rise;
  logic    tick;
  logic    wrap;
  logic [LW-1:0] len_cnt;
  logic [LW-1:0] len_rld;
  logic [AW-1:0] cnt_v   [NDEV];
  logic [AW-1:0] start_v [NDEV];
  logic    adj_v  [NDEV];
  logic [1:0] code_v [NDEV];

  wire wr_ctrl = wr_en && (reg_addr == IDX_CTRL);
  wire wr_stat = wr_en && (reg_addr == IDX_STAT);

  assign en_rise = wr_ctrl && wr_data[0] && !ctrl_q.en;
  assign tick    = xfer_done && ctrl_q.en;

  assign adj_v[0]  = ctrl_q.adj_a;
  assign adj_v[1]  = ctrl_q.adj_b;
  assign code_v[0] = ctrl_q.step_a;
  assign code_v[1] = ctrl_q.step_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= ctrl_t'(wr_data[CW-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= 1'b0;
    end else if (wrap) begin
      stat_q <= 1'b1;
    end else if (wr_stat && wr_data[0]) begin
      stat_q <= 1'b0;
    end
  end

  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    dseq_ptr #(.AW(AW)) u_ptr (
      .clk      (clk),
      .rst      (rst),
      .cnt_wr   (wr_en && (reg_addr == 3'(2 * d))),
      .start_wr (wr_en && (reg_addr == 3'(2 * d + 1))),
      .wdata    (wr_data[AW-1:0]),
      .load     (en_rise || wrap),
      .step_en  (tick && !wrap && adj_v[d]),
      .step     (step_of(code_v[d])),
      .cnt      (cnt_v[d]),
      .start    (start_v[d])
    );
  end

  dseq_len #(.LW(LW)) u_len (
    .clk     (clk),
    .rst     (rst),
    .cnt_wr  (wr_en && (reg_addr == IDX_L_CNT)),
    .rld_wr  (wr_en && (reg_addr == IDX_L_RLD)),
    .wdata   (wr_data[LW-1:0]),
    .go_load (en_rise),
    .tick    (tick),
    .wrap    (wrap),
    .cnt     (len_cnt),
    .rld     (len_rld)
  );

  assign src_addr = ctrl_q.dir ? cnt_v[1] : cnt_v[0];
  assign dst_addr = ctrl_q.dir ? cnt_v[0] : cnt_v[1];
  assign blk_done = stat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (reg_addr)
        IDX_A_CNT:   rd_data <= DW'(cnt_v[0]);
        IDX_A_START: rd_data <= DW'(start_v[0]);
        IDX_B_CNT:   rd_data <= DW'(cnt_v[1]);
        IDX_B_START: rd_data <= DW'(start_v[1]);
        IDX_L_CNT:   rd_data <= DW'(len_cnt);
        IDX_L_RLD:   rd_data <= DW'(len_rld);
        IDX_CTRL:    rd_data <= DW'(ctrl_q);
        default:     rd_data <= DW'(stat_q);
      endcase
    end
  end

endmodule

// File: rtl/dseq_channel_chk.sv
module dseq_channel_chk #(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          rd_en,
  input logic [2:0]    reg_addr,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] rd_data,
  input logic          xfer_done,
  input logic [AW-1:0] src_addr,
  input logic [AW-1:0] dst_addr,
  input logic          blk_done,
  input logic          en
);

  p_rsv_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_addr <= 3'd3) |=> (rd_data[DW-1:AW] == '0));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && (!xfer_done || !en)) |=> ($stable(src_addr) && $stable(dst_addr)));

  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (blk_done && !(wr_en && reg_addr == 3'd7 && wr_data[0])) |=> blk_done);

  p_set_cause_r7: assert property (@(posedge clk) disable iff (rst)
    (!blk_done && !xfer_done) |=> !blk_done);

  p_rd_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

endmodule

bind dseq_channel dseq_channel_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .reg_addr  (reg_addr),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .xfer_done (xfer_done),
  .src_addr  (src_addr),
  .dst_addr  (dst_addr),
  .blk_done  (blk_done),
  .en        (ctrl_q.en)
);

// File: tb/sim_dseq_channel.sv
module sim_dseq_channel;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        xfer_done = 1'b0;
  logic [23:0] src_addr;
  logic [23:0] dst_addr;
  logic        blk_done;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        pend_q = 1'b0;

  always #10 clk = ~clk;

  dseq_channel u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .rd_data(rd_data), .xfer_done(xfer_done),
    .src_addr(src_addr), .dst_addr(dst_addr), .blk_done(blk_done)
  );

  // monitor: pops one expected item per completed read
  always @(posedge clk) pend_q <= rd_en;

  always @(negedge clk) begin
    if (pend_q && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rd_data !== e) begin
        errors++;
        $display("FAIL %s: rd_data=%h expected %h", t, rd_data, e);
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic strobe = 1'b0);
    @(negedge clk);
    wr_en = 1'b1; reg_addr = a; wr_data = d; xfer_done = strobe;
    @(negedge clk);
    wr_en = 1'b0; xfer_done = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse();
    @(negedge clk);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rd(3'd6, 32'h0, "reset ctrl R12");
    rd(3'd7, 32'h0, "reset status R8");
    rd(3'd0, 32'h0, "reset A counter R1");

    wr(3'd1, 32'hFF00_0100);
    rd(3'd1, 32'h0000_0100, "R1 start reserved bits");
    wr(3'd3, 32'h0020_0000);
    wr(3'd5, 32'd3);
    wr(3'd6, 32'h9D);               // en, adjA, adjB, stepA=2, stepB=4
    chk(src_addr, 24'h000100, "R10 enable copies A / R3 src");
    chk(dst_addr, 24'h200000, "R10 enable copies B / R3 dst");
    rd(3'd4, 32'd3, "R10 length loaded");

    pulse();
    chk(src_addr, 24'h000102, "R5 step 2 on A");
    chk(dst_addr, 24'h200004, "R5 step 4 on B");
    rd(3'd4, 32'd2, "R6 length decrement");

    wr(3'd1, 32'h0000_0500);
    chk(src_addr, 24'h000102, "R2 start write leaves counter");
    pulse();
    chk(src_addr, 24'h000104, "R2 counter steps from old value");
    rd(3'd4, 32'd1, "R6 length at 1");
    pulse();
    chk(src_addr, 24'h000500, "R7 A reload");
    chk(dst_addr, 24'h200000, "R7 B reload");
    rd(3'd4, 32'd3, "R7 length reload");
    chk({31'd0, blk_done}, 32'd1, "R7 flag set");

    pulse();
    chk({31'd0, blk_done}, 32'd1, "R8 sticky");
    wr(3'd7, 32'h0);
    chk({31'd0, blk_done}, 32'd1, "R8 write 0 ignored");
    wr(3'd7, 32'h1);
    rd(3'd7, 32'h0, "R8 write 1 clears");

    pulse();                        // length 2 -> 1
    wr(3'd7, 32'h1, 1'b1);          // clear and block end together
    chk({31'd0, blk_done}, 32'd1, "R8 set wins over clear");
    chk(src_addr, 24'h000500, "R7 reload in collision");

    wr(3'd6, 32'h9F);               // dir = 1
    chk(src_addr, 24'h200000, "R3 swapped src");
    chk(dst_addr, 24'h000500, "R3 swapped dst");

    wr(3'd6, 32'hC9);               // adjA=0, adjB=1 stepB=11
    pulse();
    chk(src_addr, 24'h000500, "R4 adjust off holds A");
    chk(dst_addr, 24'h200000, "R5 step code 11 holds B");
    wr(3'd6, 32'h05);               // adjA, stepA=1
    pulse();
    chk(src_addr, 24'h000501, "R5 step 1 on A");
    rd(3'd4, 32'd1, "R6 length after two pulses");

    wr(3'd6, 32'h04);               // disable
    pulse();
    rd(3'd4, 32'd1, "R9 length unchanged while disabled");
    rd(3'd0, 32'h0000_0501, "R9 A unchanged while disabled");

    wr(3'd6, 32'h15);               // re-enable, stepA=2
    rd(3'd4, 32'd3, "R10 re-enable reloads length");
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, 32'h00FF_FFFF, "R1 counter reserved bits");
    pulse();
    rd(3'd0, 32'h0000_0001, "R11 wrap modulo 2^24");
    chk(src_addr, 24'h000001, "R11 wrap on port");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(negedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule